// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Engine

This block sends frames that software has laid out in memory as a ring of transmit buffer descriptors. Every descriptor takes eight bytes. The first word holds the buffer length and a set of flags, and the second word holds the address of the buffer. When a start pulse arrives while the global enable is high, the engine reads the descriptor at its current pointer. It then fetches that buffer one byte at a time through a single valid/ready memory port and streams the bytes out on a byte stream with a last marker. After the buffer it writes the descriptor back with the ready flag cleared and moves on to the next descriptor. It stops when it reaches a descriptor that is not ready.

One frame may span any number of descriptors. The final one is marked by a flag. A running byte count for the frame is capped at a parameter (2032 bytes by default). A buffer that would take the frame past the cap is cut short, and the engine raises a babble event. One-cycle event pulses report each buffer consumed and each frame completed, and a control-register block is expected to turn these into interrupt status. The descriptor pointer is kept between activations. It returns to the ring base whenever the enable is low.

Top module: `txbd_ring_engine`

## Requirements
- R1: Out of reset, `busy`, `mem_valid`, `tx_valid`, `evt_buf`, `evt_frame` and `evt_babble` are all low.
- R2: A `start` pulse while `enable` is high begins a descriptor read at the current pointer. A `start` pulse while `enable` is low issues no memory request and leaves `busy` low.
- R3: Descriptor word 0 carries the length in bits 15:0 and the flags in bits 31:16, and word 1 (at pointer + 4) is the buffer address. Ready is word 0 bit 31. If a fetched descriptor has ready clear, the activation ends: nothing is written back, no event fires, and the pointer stays on that descriptor.
- R4: The bytes of a buffer leave in address order starting at the buffer address, which may be unaligned. The byte at address A is lane A[1:0] (bits 8*A[1:0]+7 to 8*A[1:0]) of the word read at A with its two low bits cleared. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R5: The last-buffer flag is word 0 bit 27. Only the final byte of a frame carries `tx_last`, even when the frame spans several descriptors. If the last buffer contributes no bytes, the marker goes on the byte before it.
- R6: Once a buffer's bytes have been taken, word 0 is written back to the descriptor address unchanged except that bit 31 is cleared.
- R7: After the write-back the pointer moves on by 8, or reloads from `ring_base` when the wrap flag (word 0 bit 27+2 = bit 29) is set.
- R8: Each write-back produces one `evt_buf` pulse in the following cycle. `evt_frame` pulses in the same cycle when the buffer was the last of its frame.
- R9: A buffer adds min(length, MAX_FRAME - bytes so far) bytes to the frame. When its length is larger than the remaining room, `evt_babble` pulses together with its `evt_buf`. The count returns to zero after the last buffer of a frame.
- R10: While `enable` is low the engine is idle from the next cycle on, the pointer is loaded from `ring_base`, and any partial frame is dropped. Otherwise the pointer persists across activations.
- R11: A memory request holds `mem_valid`, `mem_addr` and `mem_we` until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable level |
| start | input | 1 | Transmit activate strobe |
| ring_base | input | ADDR_W | Ring base address (8-byte aligned) |
| busy | output | 1 | Engine is walking the ring |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a word write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data, little-endian |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| evt_buf | output | 1 | One buffer consumed (pulse) |
| evt_frame | output | 1 | One frame completed (pulse) |
| evt_babble | output | 1 | Frame byte cap hit (pulse) |

## Verification
The bench builds the engine with ADDR_W = 10, which gives a 1 KiB byte-array memory model, and with MAX_FRAME = 24. A 24-byte cap lets a two-buffer frame of 20 and 10 bytes hit the clamp after a few dozen cycles. With the same settings the bench can show that the count restarts at zero on the next frame, which would be out of reach at the 2032-byte default. The memory and sink stall on fixed patterns throughout. This exercises holding requests and bytes steady, unaligned buffer starts, ring wrap, a zero-length last buffer, and the reload of the pointer on disable.

// File: rtl/txbd_pkg.sv
// Shared definitions for the transmit descriptor ring engine.
// Assumes little-endian descriptors: word 0 = {flags, length}, word 1 = buffer address.
package txbd_pkg;
    localparam int DESC_BYTES = 8;
    localparam int FLG_READY  = 31;   // word 0 bit: descriptor owned by the engine
    localparam int FLG_WRAP   = 29;   // word 0 bit: next descriptor is at ring base
    localparam int FLG_LAST   = 27;   // word 0 bit: last buffer of the frame

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_BYTE,
        ST_FETCH,
        ST_PUSH,
        ST_FLUSH,
        ST_WB
    } txbd_state_e;
endpackage

// File: rtl/txbd_ptr_reg.sv
// Current-descriptor pointer. Reloads from the ring base while disabled,
// otherwise steps by one descriptor or wraps when told to advance.
// Assumes ring_base is descriptor aligned.
module txbd_ptr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              adv,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    import txbd_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    // Pointer register: reset/disable reload, then advance or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ptr <= ring_base;
        end else if (adv) begin
            ptr <= wrap ? ring_base : ptr + STEP;
        end
    end
endmodule

// File: rtl/txbd_len_clamp.sv
// Per-frame byte counter with the length clamp. Given a descriptor length,
// reports how many bytes may be taken and whether the cap was exceeded.
// Assumes MAX_FRAME fits in 16 bits and add/clear never coincide.
module txbd_len_clamp #(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [15:0] len,
    input  logic        add,
    input  logic        clear,
    output logic [15:0] take,
    output logic        over
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    logic [CNT_W-1:0] count;
    logic [16:0]      room;

    // Remaining room in the frame and the clamped length.
    always_comb begin
        room = 17'(MAX_FRAME) - 17'(count);
        over = {1'b0, len} > room;
        take = over ? room[15:0] : len;
    end

    // Frame byte count: grows by each accepted buffer, clears at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || clear) begin
            count <= '0;
        end else if (add) begin
            count <= count + CNT_W'(take);
        end
    end
endmodule

// File: rtl/txbd_ctrl.sv
// Sequencer: reads a descriptor, gathers its buffer byte by byte, streams it
// with a one-byte hold so the frame's last byte can carry the end marker,
// writes the descriptor back and raises event pulses.
// Assumes mem_rdata is valid in the cycle mem_valid && mem_ready.
module txbd_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [15:0]       take,
    input  logic              over,
    output logic [15:0]       desc_len,
    output logic              cnt_add,
    output logic              cnt_clear,
    output logic              ptr_adv,
    output logic              ptr_wrap,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              evt_buf,
    output logic              evt_frame,
    output logic              evt_babble
);
    import txbd_pkg::*;

    localparam logic [ADDR_W-1:0] WORD1_OFS = ADDR_W'(4);

    txbd_state_e       state;
    logic [31:0]       word0_q;
    logic [15:0]       rem;
    logic [ADDR_W-1:0] baddr;
    logic              clamp_q;
    logic              hold_v;
    logic [7:0]        hold_d;
    logic [7:0]        lane;

    // Memory request decode from the state.
    always_comb begin
        mem_valid = (state == ST_RD0) || (state == ST_RD1) ||
                    (state == ST_FETCH) || (state == ST_WB);
        mem_we    = (state == ST_WB);
        case (state)
            ST_RD1:   mem_addr = ptr + WORD1_OFS;
            ST_FETCH: mem_addr = {baddr[ADDR_W-1:2], 2'b00};
            default:  mem_addr = ptr;
        endcase
        mem_wdata = word0_q & ~(32'h1 << FLG_READY);
    end

    // Byte lane selection for the buffer fetch.
    assign lane = mem_rdata[{baddr[1:0], 3'b000} +: 8];

    // Output stream and side controls to pointer and counter.
    always_comb begin
        busy      = (state != ST_IDLE);
        tx_valid  = (state == ST_PUSH) || (state == ST_FLUSH);
        tx_last   = (state == ST_FLUSH);
        tx_data   = hold_d;
        desc_len  = mem_rdata[15:0];
        cnt_add   = enable && (state == ST_RD0) && mem_ready && mem_rdata[FLG_READY];
        cnt_clear = enable && (state == ST_WB) && mem_ready && word0_q[FLG_LAST];
        ptr_adv   = enable && (state == ST_WB) && mem_ready;
        ptr_wrap  = word0_q[FLG_WRAP];
    end

    // Sequencer state, descriptor latch, byte hold and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            word0_q    <= '0;
            rem        <= '0;
            baddr      <= '0;
            clamp_q    <= 1'b0;
            hold_v     <= 1'b0;
            hold_d     <= '0;
            evt_buf    <= 1'b0;
            evt_frame  <= 1'b0;
            evt_babble <= 1'b0;
        end else begin
            evt_buf    <= 1'b0;
            evt_frame  <= 1'b0;
            evt_babble <= 1'b0;
            if (!enable) begin
                state  <= ST_IDLE;
                hold_v <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) state <= ST_RD0;
                    end
                    ST_RD0: begin
                        if (mem_ready) begin
                            if (!mem_rdata[FLG_READY]) begin
                                state <= ST_IDLE;
                            end else begin
                                word0_q <= mem_rdata;
                                rem     <= take;
                                clamp_q <= over;
                                state   <= ST_RD1;
                            end
                        end
                    end
                    ST_RD1: begin
                        if (mem_ready) begin
                            baddr <= mem_rdata[ADDR_W-1:0];
                            state <= ST_BYTE;
                        end
                    end
                    ST_BYTE: begin
                        if (rem != 16'd0) begin
                            state <= hold_v ? ST_PUSH : ST_FETCH;
                        end else if (word0_q[FLG_LAST] && hold_v) begin
                            state <= ST_FLUSH;
                        end else begin
                            state <= ST_WB;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_ready) begin
                            hold_d <= lane;
                            hold_v <= 1'b1;
                            rem    <= rem - 16'd1;
                            baddr  <= baddr + ADDR_W'(1);
                            state  <= ST_BYTE;
                        end
                    end
                    ST_PUSH: begin
                        if (tx_ready) begin
                            hold_v <= 1'b0;
                            state  <= ST_BYTE;
                        end
                    end
                    ST_FLUSH: begin
                        if (tx_ready) begin
                            hold_v <= 1'b0;
                            state  <= ST_WB;
                        end
                    end
                    ST_WB: begin
                        if (mem_ready) begin
                            evt_buf    <= 1'b1;
                            evt_frame  <= word0_q[FLG_LAST];
                            evt_babble <= clamp_q;
                            state      <= ST_RD0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/txbd_ring_engine.sv
// Top of the transmit descriptor ring engine: pointer, frame length clamp
// and sequencer wired together. Assumes one outstanding memory request.
module txbd_ring_engine #(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              evt_buf,
    output logic              evt_frame,
    output logic              evt_babble
);
    logic [ADDR_W-1:0] ptr;
    logic [15:0]       desc_len;
    logic [15:0]       take;
    logic              over;
    logic              cnt_add;
    logic              cnt_clear;
    logic              ptr_adv;
    logic              ptr_wrap;

    txbd_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ring_base (ring_base),
        .adv       (ptr_adv),
        .wrap      (ptr_wrap),
        .ptr       (ptr)
    );

    txbd_len_clamp #(.MAX_FRAME(MAX_FRAME)) u_clamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .len    (desc_len),
        .add    (cnt_add),
        .clear  (cnt_clear),
        .take   (take),
        .over   (over)
    );

    txbd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (start),
        .ptr        (ptr),
        .take       (take),
        .over       (over),
        .desc_len   (desc_len),
        .cnt_add    (cnt_add),
        .cnt_clear  (cnt_clear),
        .ptr_adv    (ptr_adv),
        .ptr_wrap   (ptr_wrap),
        .busy       (busy),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .evt_buf    (evt_buf),
        .evt_frame  (evt_frame),
        .evt_babble (evt_babble)
    );
endmodule

// File: rtl/txbd_ring_engine_chk.sv
// Protocol and event checker for the ring engine, bound to its top module.
module txbd_ring_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              busy,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              evt_buf,
    input logic              evt_frame,
    input logic              evt_babble
);
    a_r2_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !mem_valid));

    a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && enable) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r5_tx_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    a_r6_wb_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> !mem_wdata[31]);

    a_r8_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> evt_buf);

    a_r8_buf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf |-> $past(mem_valid && mem_we && mem_ready));

    a_r9_babble_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
        evt_babble |-> evt_buf);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && enable) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .busy       (busy),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .evt_buf    (evt_buf),
    .evt_frame  (evt_frame),
    .evt_babble (evt_babble)
);

// File: tb/txbd_ring_engine_bench.sv
`timescale 1ns/1ps
module txbd_ring_engine_bench;
    localparam int AW   = 10;
    localparam int MAXF = 24;
    localparam logic [15:0] RDY = 16'h8000;
    localparam logic [15:0] WRP = 16'h2000;
    localparam logic [15:0] LST = 16'h0800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] ring_base = 10'h100;
    logic          busy, mem_valid, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          tx_valid, tx_last, tx_ready;
    logic [7:0]    tx_data;
    logic          evt_buf, evt_frame, evt_babble;

    logic [7:0] mem [0:1023];
    logic [7:0] cap_d[$];
    logic       cap_l[$];
    logic [7:0] exp_d[$];
    logic       exp_l[$];
    int n_chk = 0, n_err = 0;
    int n_buf = 0, n_frm = 0, n_bab = 0, n_xfer = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txbd_ring_engine #(.ADDR_W(AW), .MAX_FRAME(MAXF)) u_txbd_ring_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .ring_base(ring_base),
        .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .evt_buf(evt_buf), .evt_frame(evt_frame), .evt_babble(evt_babble)
    );

    // Little-endian word read model.
    assign mem_rdata = {mem[{mem_addr[AW-1:2], 2'b11}], mem[{mem_addr[AW-1:2], 2'b10}],
                        mem[{mem_addr[AW-1:2], 2'b01}], mem[{mem_addr[AW-1:2], 2'b00}]};

    // Stall patterns, driven away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_ready = mem_valid && (cyc % 3 != 0);
        tx_ready  = (cyc % 4 != 1);
    end

    // Memory writes, stream capture and event counting.
    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            n_xfer = n_xfer + 1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    mem[{mem_addr[AW-1:2], 2'(b)}] = mem_wdata[8*b +: 8];
            end
        end
        if (tx_valid && tx_ready) begin
            cap_d.push_back(tx_data);
            cap_l.push_back(tx_last);
        end
        if (evt_buf)    n_buf = n_buf + 1;
        if (evt_frame)  n_frm = n_frm + 1;
        if (evt_babble) n_bab = n_bab + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [15:0] flg, input logic [15:0] len, input int buf_a);
        logic [31:0] w0;
        w0 = {flg, len};
        for (int b = 0; b < 4; b++) begin
            mem[a + b]     = w0[8*b +: 8];
            mem[a + 4 + b] = 8'(buf_a >> (8*b));
        end
    endtask

    function automatic int word0(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic fill(input int a, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[a + i] = 8'((a + i) * 7 + seed);
    endtask

    task automatic expect_seg(input int a, input int n, input bit last_end);
        for (int i = 0; i < n; i++) begin
            exp_d.push_back(mem[a + i]);
            exp_l.push_back(last_end && (i == n - 1));
        end
    endtask

    task automatic begin_test();
        cap_d.delete(); cap_l.delete(); exp_d.delete(); exp_l.delete();
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input string tag);
        int bd = 0, bl = 0;
        chk("R4", {tag, " byte count"}, cap_d.size(), exp_d.size());
        if (cap_d.size() == exp_d.size()) begin
            for (int i = 0; i < cap_d.size(); i++) begin
                if (cap_d[i] !== exp_d[i]) bd++;
                if (cap_l[i] !== exp_l[i]) bl++;
            end
        end
        chk("R4 R11", {tag, " data mismatches"}, bd, 0);
        chk("R5", {tag, " last marker mismatches"}, bl, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "tx_valid", tx_valid, 0);
        chk("R1", "events", {evt_buf, evt_frame, evt_babble}, 0);
    endtask

    task automatic t_single();
        int b0 = n_buf, f0 = n_frm, k0 = n_bab;
        begin_test();
        put_desc('h100, RDY | LST, 16'd5, 'h201);
        fill('h201, 5, 3);
        expect_seg('h201, 5, 1);
        kick();
        cmp_stream("single");
        chk("R6", "write-back word0", word0('h100), {LST, 16'd5});
        chk("R8", "buffer events", n_buf - b0, 1);
        chk("R8", "frame events", n_frm - f0, 1);
        chk("R9", "babble events", n_bab - k0, 0);
    endtask

    task automatic t_multi_stop();
        int b0 = n_buf, f0 = n_frm;
        begin_test();
        put_desc('h108, RDY, 16'd3, 'h240);
        put_desc('h110, RDY | LST, 16'd4, 'h283);
        put_desc('h118, 16'h0000, 16'd9, 'h2A0);
        fill('h240, 3, 5); fill('h283, 4, 9);
        expect_seg('h240, 3, 0); expect_seg('h283, 4, 1);
        kick();
        cmp_stream("multi");
        chk("R8", "buffer events", n_buf - b0, 2);
        chk("R8", "frame events", n_frm - f0, 1);
        chk("R3", "not-ready descriptor untouched", word0('h118), {16'h0000, 16'd9});
        chk("R3", "idle after not-ready", busy, 0);
    endtask

    task automatic t_resume_wrap();
        int f0 = n_frm;
        begin_test();
        put_desc('h118, RDY | LST | WRP, 16'd2, 'h2C0);
        put_desc('h100, RDY | LST, 16'd1, 'h2E0);
        fill('h2C0, 2, 11); fill('h2E0, 1, 13);
        expect_seg('h2C0, 2, 1); expect_seg('h2E0, 1, 1);
        kick();
        cmp_stream("resume/wrap");
        chk("R7", "wrap then base descriptor consumed", word0('h100), {LST, 16'd1});
        chk("R8", "frame events", n_frm - f0, 2);
    endtask

    task automatic t_clamp();
        int k0 = n_bab, f0 = n_frm;
        begin_test();
        put_desc('h108, RDY, 16'd20, 'h300);
        put_desc('h110, RDY | LST, 16'd10, 'h320);
        fill('h300, 20, 17); fill('h320, 10, 19);
        expect_seg('h300, 20, 0); expect_seg('h320, 4, 1);
        kick();
        cmp_stream("clamp");
        chk("R9", "babble events", n_bab - k0, 1);
        chk("R9", "frame events", n_frm - f0, 1);
        chk("R6", "length kept on write-back", word0('h110), {LST, 16'd10});
    endtask

    task automatic t_after_clamp();
        int k0 = n_bab;
        begin_test();
        put_desc('h118, RDY | LST | WRP, 16'd3, 'h340);
        fill('h340, 3, 23);
        expect_seg('h340, 3, 1);
        kick();
        cmp_stream("after clamp");
        chk("R9", "count reset, no babble", n_bab - k0, 0);
    endtask

    task automatic t_disable();
        int x0;
        begin_test();
        put_desc('h100, RDY | LST, 16'd1, 'h360);
        fill('h360, 1, 29);
        expect_seg('h360, 1, 1);
        kick();
        cmp_stream("pre-disable");
        begin_test();
        @(negedge clk); enable = 1'b0; ring_base = 10'h180;
        x0 = n_xfer;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R2", "memory requests while disabled", n_xfer - x0, 0);
        chk("R2", "busy while disabled", busy, 0);
        put_desc('h108, RDY | LST, 16'd6, 'h390);
        put_desc('h180, RDY | LST, 16'd2, 'h380);
        put_desc('h188, 16'h0000, 16'd0, 'h000);
        fill('h380, 2, 31); fill('h390, 6, 37);
        expect_seg('h380, 2, 1);
        @(negedge clk); enable = 1'b1;
        kick();
        cmp_stream("R10 pointer reload");
        chk("R10", "trap descriptor untouched", word0('h108), {RDY | LST, 16'd6});
    endtask

    task automatic t_zero_last();
        int b0 = n_buf, f0 = n_frm;
        begin_test();
        put_desc('h188, RDY, 16'd3, 'h3A1);
        put_desc('h190, RDY | LST, 16'd0, 'h3C0);
        put_desc('h198, 16'h0000, 16'd0, 'h000);
        fill('h3A1, 3, 41);
        expect_seg('h3A1, 3, 1);
        kick();
        cmp_stream("zero-length last");
        chk("R8", "buffer events", n_buf - b0, 2);
        chk("R8", "frame events", n_frm - f0, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem_ready = 1'b0;
        tx_ready = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        enable = 1'b1;
        @(negedge clk);
        t_single();
        t_multi_stop();
        t_resume_wrap();
        t_clamp();
        t_after_clamp();
        t_disable();
        t_zero_last();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule